// File: doc/BRIEF.md
# Multiplexed Address/Data Read Sequencer

This block runs read cycles to an external memory over a 16-bit bus that carries the address first and the data afterwards. The core side gives a request level, a start address and a strobe count. Each bus cycle has the same shape. The block drives the address and holds an address latch enable active so the memory can latch the address. It keeps the address on the bus for one more peripheral tick and then releases the bus. It then issues one or more active-low read strobes. Data is sampled at the edge where each strobe rises. Every sampled halfword goes back to the core with its address and a valid pulse that lasts one clock.

All sequencing runs on a peripheral tick, which is one enable out of every two core clocks. Several settings are taken from the inputs when a request is accepted:
- the strobe width;
- an optional hold tick after each strobe;
- a seven-tick flash recovery stretch;
- the packing mode.

The latch enable polarity is applied live. Software changes it only while the block is idle.

Top module: `mad_rd_seq`

## Requirements
- R1: While reset is applied and right after it, `busy` is low, `ad_oe` is low, `rd_n` is high, `rd_valid` is low and `ale` sits at its inactive level.
- R2: The latch enable is active for exactly 2 ticks (4 core clocks). For that whole time `ad_oe` is high and `ad_out` carries the request address. The inactive level of `ale` equals `cfg_ale_low`, so 0 selects active-high and 1 selects active-low.
- R3: `ad_oe` stays high for exactly 1 tick after the latch enable deasserts. After that it stays low for the rest of the cycle, and it is never high while `rd_n` is low.
- R4: `rd_n` falls 2 ticks after the latch enable deasserts and stays low for D ticks, where D is `cfg_dur`. A value of 0 gives a width of 1.
- R5: At the clock edge where `rd_n` rises, the block samples `ad_in` into `rd_data`. `rd_valid` is high for exactly the one core clock that follows that edge.
- R6: Between two strobes of one cycle, `rd_n` stays high for exactly H+1 ticks. H is 1 when `cfg_hold` is set and 0 otherwise.
- R7: After the last strobe rises, the block stays busy for H+1 ticks, plus 7 more when `cfg_flash` is set. It then returns to idle.
- R8: With `cfg_single`=1, each latch enable is followed by exactly one strobe. With `cfg_single`=0 it is followed by `req_count` strobes, where 0 counts as 1. `rd_addr` starts at the request address and increases by 1 per strobe, modulo 2^16.
- R9: The address, count, width, hold, flash and packing inputs are taken at acceptance. Changing them during a cycle has no effect on that cycle.
- R10: The state advances only on every second core clock, starting with the second rising edge after reset. A request is accepted only on such an edge while the block is idle. `busy` is high from acceptance until the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request level, held until `busy` rises |
| req_addr | input | 16 | Start address |
| req_count | input | 4 | Strobes per latch in multi-strobe mode (0 means 1) |
| cfg_dur | input | 5 | Strobe width in ticks (0 means 1) |
| cfg_hold | input | 1 | Adds one hold tick after each strobe |
| cfg_flash | input | 1 | Adds seven recovery ticks after the last strobe |
| cfg_single | input | 1 | 1: one strobe per latch; 0: multi-strobe |
| cfg_ale_low | input | 1 | Latch enable polarity: 1 makes it active low |
| busy | output | 1 | A bus cycle is in progress |
| ad_out | output | 16 | Address driven onto the shared bus |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 16 | Data read back from the shared bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| rd_data | output | 16 | Sampled halfword |
| rd_addr | output | 16 | Address of the sampled halfword |
| rd_valid | output | 1 | One-clock pulse marking a new halfword |

## Verification
The polarity checks take for granted that `cfg_ale_low` is constant for the whole of any bus cycle. The stimulus therefore changes it only while `busy` is low. The properties also assume a request is held until `busy` rises and is then released, so a single request never starts two cycles. The bench keeps to that handshake. It alters the other settings only after acceptance, which is how R9 is exercised.

// File: rtl/mad_rd_pkg.sv
package mad_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALE,
      ST_AHOLD,
      ST_TURN,
      ST_STRB,
      ST_RECOV,
      ST_FLASH
   } seq_st_e;

   typedef struct packed {
      logic hold;
      logic flash;
      logic single;
   } rd_mode_t;

endpackage

// File: rtl/mad_pclk_en.sv
module mad_pclk_en #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic en
);

   generate
      if (DIV == 1) begin : g_full_rate
         // Every core clock is a peripheral tick once reset is released.
         assign en = rst_n;
      end else if (DIV == 2) begin : g_half_rate
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= 1'b0;
            else        ph_q <= ~ph_q;
         end
         assign en = ph_q;
      end else begin : g_bad_div
         $error("mad_pclk_en: DIV must be 1 or 2");
         assign en = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mad_rd_ctrl.sv
module mad_rd_ctrl
   import mad_rd_pkg::*;
#(
   parameter int DW          = 16,
   parameter int CNT_W       = 4,
   parameter int DUR_W       = 5,
   parameter int ALE_TICKS   = 2,
   parameter int FLASH_TICKS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             req,
   input  logic [DW-1:0]    req_addr,
   input  logic [CNT_W-1:0] req_count,
   input  logic [DUR_W-1:0] cfg_dur,
   input  rd_mode_t         mode_in,
   output seq_st_e          st,
   output logic [DW-1:0]    base_addr,
   output logic [DW-1:0]    cur_addr,
   output logic             strobe_end
);

   localparam int FW    = $clog2(FLASH_TICKS + 1);
   localparam int AW    = $clog2(ALE_TICKS + 1);
   localparam int CW_A  = (DUR_W > FW) ? DUR_W : FW;
   localparam int CW    = (CW_A > AW) ? CW_A : AW;

   logic [CW-1:0]    tcnt;
   logic [CNT_W-1:0] left;
   logic [DUR_W-1:0] dur_m1;
   rd_mode_t         mode_q;
   logic             tc_zero;

   assign tc_zero    = (tcnt == '0);
   assign strobe_end = en && (st == ST_STRB) && tc_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tcnt      <= '0;
         left      <= '0;
         dur_m1    <= '0;
         mode_q    <= '0;
         base_addr <= '0;
         cur_addr  <= '0;
      end else if (en) begin
         unique case (st)
            ST_IDLE: begin
               if (req) begin
                  st        <= ST_ALE;
                  tcnt      <= CW'(ALE_TICKS - 1);
                  base_addr <= req_addr;
                  cur_addr  <= req_addr;
                  mode_q    <= mode_in;
                  dur_m1    <= (cfg_dur == '0) ? '0 : cfg_dur - 1'b1;
                  if (mode_in.single || (req_count == '0)) left <= CNT_W'(1);
                  else                                     left <= req_count;
               end
            end
            ST_ALE: begin
               if (tc_zero) st <= ST_AHOLD;
               else         tcnt <= tcnt - 1'b1;
            end
            ST_AHOLD: st <= ST_TURN;
            ST_TURN: begin
               st   <= ST_STRB;
               tcnt <= CW'(dur_m1);
            end
            ST_STRB: begin
               if (tc_zero) begin
                  st       <= ST_RECOV;
                  tcnt     <= mode_q.hold ? CW'(1) : '0;
                  left     <= left - 1'b1;
                  cur_addr <= cur_addr + 1'b1;
               end else begin
                  tcnt <= tcnt - 1'b1;
               end
            end
            ST_RECOV: begin
               if (tc_zero) begin
                  if (left != '0) begin
                     st   <= ST_STRB;
                     tcnt <= CW'(dur_m1);
                  end else if (mode_q.flash) begin
                     st   <= ST_FLASH;
                     tcnt <= CW'(FLASH_TICKS - 1);
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  tcnt <= tcnt - 1'b1;
               end
            end
            ST_FLASH: begin
               if (tc_zero) st <= ST_IDLE;
               else         tcnt <= tcnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mad_rd_cap.sv
module mad_rd_cap #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_end,
   input  logic [DW-1:0] ad_in,
   input  logic [DW-1:0] cur_addr,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] rd_addr,
   output logic          rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_addr  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= strobe_end;
         if (strobe_end) begin
            rd_data <= ad_in;
            rd_addr <= cur_addr;
         end
      end
   end

endmodule

// File: rtl/mad_rd_seq.sv
module mad_rd_seq
   import mad_rd_pkg::*;
#(
   parameter int DW          = 16,
   parameter int CNT_W       = 4,
   parameter int DUR_W       = 5,
   parameter int ALE_TICKS   = 2,
   parameter int FLASH_TICKS = 7,
   parameter int PCLK_DIV    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [DW-1:0]    req_addr,
   input  logic [CNT_W-1:0] req_count,
   input  logic [DUR_W-1:0] cfg_dur,
   input  logic             cfg_hold,
   input  logic             cfg_flash,
   input  logic             cfg_single,
   input  logic             cfg_ale_low,
   output logic             busy,
   output logic [DW-1:0]    ad_out,
   output logic             ad_oe,
   input  logic [DW-1:0]    ad_in,
   output logic             ale,
   output logic             rd_n,
   output logic [DW-1:0]    rd_data,
   output logic [DW-1:0]    rd_addr,
   output logic             rd_valid
);

   generate
      if (DW < 1)          begin : g_chk_dw  $error("mad_rd_seq: DW must be positive"); end
      if (CNT_W < 1)       begin : g_chk_cnt $error("mad_rd_seq: CNT_W must be positive"); end
      if (DUR_W < 1)       begin : g_chk_dur $error("mad_rd_seq: DUR_W must be positive"); end
      if (ALE_TICKS < 1)   begin : g_chk_ale $error("mad_rd_seq: ALE_TICKS must be positive"); end
      if (FLASH_TICKS < 1) begin : g_chk_fl  $error("mad_rd_seq: FLASH_TICKS must be positive"); end
   endgenerate

   logic          tick;
   seq_st_e       st;
   logic [DW-1:0] base_addr;
   logic [DW-1:0] cur_addr;
   logic          strobe_end;
   rd_mode_t      mode_in;

   assign mode_in = '{hold: cfg_hold, flash: cfg_flash, single: cfg_single};

   mad_pclk_en #(.DIV(PCLK_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tick)
   );

   mad_rd_ctrl #(
      .DW          (DW),
      .CNT_W       (CNT_W),
      .DUR_W       (DUR_W),
      .ALE_TICKS   (ALE_TICKS),
      .FLASH_TICKS (FLASH_TICKS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tick),
      .req        (req),
      .req_addr   (req_addr),
      .req_count  (req_count),
      .cfg_dur    (cfg_dur),
      .mode_in    (mode_in),
      .st         (st),
      .base_addr  (base_addr),
      .cur_addr   (cur_addr),
      .strobe_end (strobe_end)
   );

   mad_rd_cap #(.DW(DW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_end (strobe_end),
      .ad_in      (ad_in),
      .cur_addr   (cur_addr),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .rd_valid   (rd_valid)
   );

   // Pin decode from the registered phase.
   assign busy   = (st != ST_IDLE);
   assign ad_oe  = (st == ST_ALE) || (st == ST_AHOLD);
   assign ad_out = ad_oe ? base_addr : '0;
   assign ale    = (st == ST_ALE) ^ cfg_ale_low;
   assign rd_n   = (st != ST_STRB);

endmodule

// File: rtl/mad_rd_seq_chk.sv
module mad_rd_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic ale,
   input logic cfg_ale_low,
   input logic ad_oe,
   input logic rd_n,
   input logic rd_valid
);

   // R2
   ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ale != cfg_ale_low) |-> ad_oe);

   // R3
   bus_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R3
   addr_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ad_oe) |-> ((ale == cfg_ale_low) && ($past(ale) == cfg_ale_low)));

   // R5
   valid_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(rd_n));

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_n && !ad_oe));

   // R10
   busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

endmodule

bind mad_rd_seq mad_rd_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .ale         (ale),
   .cfg_ale_low (cfg_ale_low),
   .ad_oe       (ad_oe),
   .rd_n        (rd_n),
   .rd_valid    (rd_valid)
);

// File: tb/sim_mad_rd_seq.sv
module sim_mad_rd_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_count = '0;
   logic [4:0]  cfg_dur = '0;
   logic        cfg_hold = 1'b0, cfg_flash = 1'b0, cfg_single = 1'b1, cfg_ale_low = 1'b0;
   logic        busy, ad_oe, ale, rd_n, rd_valid;
   logic [15:0] ad_out, ad_in, rd_data, rd_addr;

   int nchk = 0, nfail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mad_rd_seq u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_count(req_count),
      .cfg_dur(cfg_dur), .cfg_hold(cfg_hold), .cfg_flash(cfg_flash), .cfg_single(cfg_single),
      .cfg_ale_low(cfg_ale_low), .busy(busy), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .rd_data(rd_data), .rd_addr(rd_addr), .rd_valid(rd_valid)
   );

   function automatic logic [15:0] memf(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h5A3C;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // External memory: latches the address during the latch enable, steps after each strobe.
   logic [15:0] mptr;
   logic        low_q;
   assign ad_in = rd_n ? 16'h0000 : memf(mptr);
   always @(posedge clk) begin
      if (!rst_n) begin
         mptr  <= '0;
         low_q <= 1'b0;
      end else if (ad_oe && (ale != cfg_ale_low)) begin
         mptr <= ad_out;
      end else if (!rd_n) begin
         low_q <= 1'b1;
      end else if (low_q) begin
         mptr  <= mptr + 16'd1;
         low_q <= 1'b0;
      end
   end

   // Reference model: one queue entry per tick, bits {capture, strobe, drive, latch}.
   logic [3:0]  q[$];
   logic [3:0]  m_cur;
   bit          m_busy, m_valid;
   int          m_ph;
   logic [15:0] m_base, m_addr, m_data, m_vaddr;
   int          bn, bd, bh;

   task automatic push_n(input logic [3:0] v, input int n);
      for (int i = 0; i < n; i++) q.push_back(v);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_busy = 0; m_cur = '0; m_valid = 0; q.delete();
         m_base = '0; m_addr = '0; m_data = '0; m_vaddr = '0;
      end else begin
         m_valid = 0;
         if (m_ph % 2 == 1) begin
            if (m_busy && m_cur[3]) begin
               m_valid = 1; m_data = memf(m_addr); m_vaddr = m_addr; m_addr = m_addr + 16'd1;
            end
            if (m_busy) begin
               if (q.size() > 0) m_cur = q.pop_front();
               else begin m_busy = 0; m_cur = '0; end
            end else if (req) begin
               bn = cfg_single ? 1 : ((req_count == 0) ? 1 : int'(req_count));
               bd = (cfg_dur == 0) ? 1 : int'(cfg_dur);
               bh = cfg_hold ? 1 : 0;
               push_n(4'b0011, 2);
               push_n(4'b0010, 1);
               push_n(4'b0000, 1);
               for (int k = 0; k < bn; k++) begin
                  push_n(4'b0100, bd - 1);
                  push_n(4'b1100, 1);
                  push_n(4'b0000, bh + 1);
                  if (k == bn - 1 && cfg_flash) push_n(4'b0000, 7);
               end
               m_base = req_addr; m_addr = req_addr;
               m_cur = q.pop_front(); m_busy = 1;
            end
         end
         m_ph = m_ph + 1;
      end
   end

   // Per-clock comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy === m_busy, "R10 busy", busy, m_busy);
         chk(ale === (m_cur[0] ^ cfg_ale_low), "R2 ale", ale, m_cur[0] ^ cfg_ale_low);
         chk(ad_oe === m_cur[1], "R3 ad_oe", ad_oe, m_cur[1]);
         if (m_cur[1]) chk(ad_out === m_base, "R2 ad_out", ad_out, m_base);
         chk(rd_n === !m_cur[2], "R4 rd_n", rd_n, !m_cur[2]);
         chk(rd_valid === m_valid, "R5 rd_valid", rd_valid, m_valid);
         if (m_valid) begin
            chk(rd_data === m_data, "R5 rd_data", rd_data, m_data);
            chk(rd_addr === m_vaddr, "R8 rd_addr", rd_addr, m_vaddr);
         end
      end
   end

   // Strobe shape monitor (core clock counts).
   int  mon_n, mon_w, mon_gap, mon_tail, run_lo, run_hi;
   bit  busy_d;
   always @(negedge clk) begin
      if (!rst_n) begin
         busy_d = 0; mon_n = 0; mon_w = 0; mon_gap = -1; mon_tail = 0; run_lo = 0; run_hi = 0;
      end else begin
         if (busy && !busy_d) begin
            mon_n = 0; mon_w = 0; mon_gap = -1; run_lo = 0; run_hi = 0;
         end
         if (!rd_n) begin
            if (run_lo == 0 && mon_n > 0) mon_gap = run_hi;
            run_lo++; run_hi = 0;
         end else begin
            if (run_lo > 0) begin mon_w = run_lo; mon_n++; run_lo = 0; run_hi = 0; end
            if (busy) run_hi++;
         end
         if (!busy && busy_d) mon_tail = run_hi;
         busy_d = busy;
      end
   end

   task automatic run_txn(input logic [15:0] a, input logic [3:0] cnt, input logic [4:0] dur,
                          input bit h, input bit f, input bit single, input bit scramble);
      int n, d;
      n = single ? 1 : ((cnt == 0) ? 1 : int'(cnt));
      d = (dur == 0) ? 1 : int'(dur);
      @(negedge clk);
      req_addr = a; req_count = cnt; cfg_dur = dur;
      cfg_hold = h; cfg_flash = f; cfg_single = single; req = 1'b1;
      while (!busy) @(negedge clk);
      req = 1'b0;
      if (scramble) begin
         req_addr = ~a; req_count = ~cnt; cfg_dur = ~dur;
         cfg_hold = ~h; cfg_flash = ~f; cfg_single = ~single;
      end
      while (busy) @(negedge clk);
      repeat (2) @(posedge clk);
      chk(mon_n == n, scramble ? "R9 strobes" : "R8 strobes", mon_n, n);
      chk(mon_w == 2 * d, scramble ? "R9 width" : "R4 width", mon_w, 2 * d);
      if (n > 1) chk(mon_gap == 2 * (int'(h) + 1), "R6 gap", mon_gap, 2 * (int'(h) + 1));
      chk(mon_tail == 2 * (int'(h) + 1 + 7 * int'(f)), "R7 tail", mon_tail,
          2 * (int'(h) + 1 + 7 * int'(f)));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      nchk++; nfail++;
      $display("FAIL R10 watchdog expired act=1 exp=0");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      chk(busy === 1'b0 && ad_oe === 1'b0 && rd_n === 1'b1 && rd_valid === 1'b0,
          "R1 reset outputs", {busy, ad_oe, rd_n, rd_valid}, 4'b0010);
      chk(ale === cfg_ale_low, "R1 ale idle", ale, cfg_ale_low);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && rd_n === 1'b1, "R1 after release", {busy, rd_n}, 2'b01);

      run_txn(16'h1234, 4'd0, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0);
      run_txn(16'h0800, 4'd0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0);
      run_txn(16'h2000, 4'd4, 5'd2,  1'b1, 1'b0, 1'b0, 1'b0);
      run_txn(16'h3000, 4'd0, 5'd1,  1'b0, 1'b0, 1'b0, 1'b0);
      run_txn(16'h4440, 4'd3, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0);
      @(negedge clk); cfg_ale_low = 1'b1;
      @(negedge clk);
      chk(ale === 1'b1, "R2 idle level active-low", ale, 1'b1);
      run_txn(16'h5A5A, 4'd2, 5'd1,  1'b1, 1'b1, 1'b0, 1'b0);
      run_txn(16'h6000, 4'd6, 5'd2,  1'b0, 1'b0, 1'b1, 1'b0);
      @(negedge clk); cfg_ale_low = 1'b0;
      run_txn(16'h7100, 4'd5, 5'd4,  1'b0, 1'b0, 1'b0, 1'b1);
      run_txn(16'hFFFF, 4'd3, 5'd2,  1'b0, 1'b1, 1'b0, 1'b0);
      run_txn(16'h0010, 4'd15, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0);

      repeat (6) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule